// File: doc/BRIEF.md
# Self-Invalidating Private Word Cache Controller

This block is a private first-level cache controller for one core. Coherence is driven by software and not by messages from other caches. The cache is direct-mapped. Every line holds exactly one data word and one of three stable states: Invalid, Valid or Registered. There are no transient line states. Each line also keeps a region tag that the core supplies with every access. Loads that hit are answered locally. Loads that miss fetch the word from the shared second level. A store makes its line Registered, and a registration message tells the shared level that this core now holds the only current copy of the word.

When a parallel phase ends, software pulses a phase-end strobe together with a bitmask of the regions written during that phase. In one cycle the controller drops every Valid line whose region bit is set. Registered lines were written by this core, so they survive. Lines whose region bit is clear keep their state. A Registered line that a conflicting access displaces is first written back to the shared level.

The controller has five states. IDLE accepts core requests and applies self-invalidation. EVICT writes back a displaced Registered word. REGISTER announces ownership of a stored word. FETCH issues a read for a load miss. FILL waits for the read data. The transitions are:
- IDLE to IDLE on a load hit, a store to a Registered hit, or an invalidation cycle.
- IDLE to EVICT when a miss displaces a Registered line with another tag.
- IDLE to REGISTER on a store that needs registration and displaces nothing.
- IDLE to FETCH on a load miss that displaces nothing.
- EVICT to REGISTER (store) or to FETCH (load) once the write-back is taken.
- REGISTER to IDLE once the registration is taken.
- FETCH to FILL once the read is taken.
- FILL to IDLE when the read data returns.

Top module: `l1si_cache`

## Requirements
- R1: After reset every line is Invalid, req_ready is 1, resp_valid is 0 and mem_req_valid is 0.
- R2: A load that hits a Valid or Registered line with a matching tag gives resp_valid with the stored word one cycle after acceptance and sends no request to the shared level.
- R3: A load miss sends a read request (mem_req_op = 0) for the word address. The line becomes Valid with the returned word, and the response follows one cycle after mem_resp_valid. req_ready stays low while any shared-level request is outstanding.
- R4: A store leaves its line Registered with the new word and returns that word as its response. A store to a line that is not yet Registered for that address first sends a registration request (mem_req_op = 1) carrying the address and word. A store that hits a Registered line sends nothing.
- R5: A miss whose index holds a Registered line with another tag first sends a write-back (mem_req_op = 2) with the displaced word and its full address.
- R6: On phase end, every Valid line whose region bit is set in phase_mask becomes Invalid, so its next load misses. Registered lines in such regions keep their data and state.
- R7: On phase end, lines whose region bit is clear in phase_mask keep their state and keep hitting.
- R8: req_ready is low in the cycle phase_end is applied. A request presented in that same cycle is accepted only afterwards and sees the invalidated state.
- R9: A phase_end that arrives while a miss or store is in progress is held (several masks are ORed) and applied in the first idle cycle, before any new request is accepted.
- R10: While mem_req_valid is high and mem_req_ready is low, the request's op, address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller accepts a core request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_region | input | RGN_W | Region tag of the access |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | Core response strobe |
| resp_rdata | output | DATA_W | Loaded word, or the stored word for a store |
| phase_end | input | 1 | End-of-phase self-invalidate strobe |
| phase_mask | input | REGIONS | Regions written in the ending phase |
| mem_req_valid | output | 1 | Request to the shared level |
| mem_req_ready | input | 1 | Shared level takes the request |
| mem_req_op | output | 2 | 0 read, 1 register, 2 write-back |
| mem_req_addr | output | ADDR_W | Word address of the request |
| mem_req_wdata | output | DATA_W | Word carried by register or write-back |
| mem_resp_valid | input | 1 | Read data returning |
| mem_resp_rdata | input | DATA_W | Returned word |

## Verification
Self-invalidation and acceptance of a core request compete for the same idle cycle. The bench provokes this by raising phase_end and a load to a Valid line in a masked region at the same falling edge. It judges the result by three observations: req_ready is low in that cycle, it is high in the next, and the load then costs exactly one extra shared-level read. A second case raises phase_end while a fill is outstanding. The bench then confirms that the held mask invalidates a line before the next load is served. The shared-level model alternates its ready signal so that every request also has to hold steady for a cycle.

// File: rtl/l1si_pkg.sv
package l1si_pkg;

    typedef enum logic [1:0] {
        LS_INVALID    = 2'd0,
        LS_VALID      = 2'd1,
        LS_REGISTERED = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        MOP_READ      = 2'd0,
        MOP_REGISTER  = 2'd1,
        MOP_WRITEBACK = 2'd2
    } mem_op_e;

    typedef enum logic [2:0] {
        C_IDLE,
        C_EVICT,
        C_REGISTER,
        C_FETCH,
        C_FILL
    } ctrl_state_e;

endpackage

// File: rtl/l1si_line_array.sv
module l1si_line_array
    import l1si_pkg::*;
#(
    parameter int LINES   = 8,
    parameter int TAG_W   = 5,
    parameter int REGIONS = 8,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int RGN_W  = $clog2(REGIONS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output line_state_e        rd_state,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [RGN_W-1:0]   rd_region,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  line_state_e        wr_state,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [RGN_W-1:0]   wr_region,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               inv_en,
    input  logic [REGIONS-1:0] inv_mask
);

    line_state_e        st_q   [LINES];
    logic [TAG_W-1:0]   tag_q  [LINES];
    logic [RGN_W-1:0]   rgn_q  [LINES];
    logic [DATA_W-1:0]  data_q [LINES];
    logic [LINES-1:0]   kill;

    // Per-line self-invalidate decision: only clean copies in masked regions.
    for (genvar g = 0; g < LINES; g++) begin : g_kill
        assign kill[g] = inv_en && (st_q[g] == LS_VALID) && inv_mask[rgn_q[g]];
    end

    assign rd_state  = st_q[rd_idx];
    assign rd_tag    = tag_q[rd_idx];
    assign rd_region = rgn_q[rd_idx];
    assign rd_data   = data_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= LS_INVALID;
                tag_q[i]  <= '0;
                rgn_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (kill[i]) st_q[i] <= LS_INVALID;
            end
            if (wr_en) begin
                st_q[wr_idx]   <= wr_state;
                tag_q[wr_idx]  <= wr_tag;
                rgn_q[wr_idx]  <= wr_region;
                data_q[wr_idx] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/l1si_ctrl.sv
module l1si_ctrl
    import l1si_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int LINES   = 8,
    parameter int REGIONS = 8,
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int RGN_W  = $clog2(REGIONS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [RGN_W-1:0]   req_region,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               resp_valid,
    output logic [DATA_W-1:0]  resp_rdata,
    input  logic               phase_end,
    input  logic [REGIONS-1:0] phase_mask,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output mem_op_e            mem_req_op,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [DATA_W-1:0]  mem_req_wdata,
    input  logic               mem_resp_valid,
    input  logic [DATA_W-1:0]  mem_resp_rdata,
    output logic [IDX_W-1:0]   look_idx,
    input  line_state_e        rd_state,
    input  logic [TAG_W-1:0]   rd_tag,
    input  logic [RGN_W-1:0]   rd_region,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               wr_en,
    output line_state_e        wr_state,
    output logic [TAG_W-1:0]   wr_tag,
    output logic [RGN_W-1:0]   wr_region,
    output logic [DATA_W-1:0]  wr_data,
    output logic               inv_en,
    output logic [REGIONS-1:0] inv_mask
);

    ctrl_state_e        state_q, state_d;
    logic               cur_we_q;
    logic [ADDR_W-1:0]  cur_addr_q;
    logic [RGN_W-1:0]   cur_region_q;
    logic [DATA_W-1:0]  cur_wdata_q;
    logic [ADDR_W-1:0]  vict_addr_q;
    logic [DATA_W-1:0]  vict_data_q;
    logic               pend_q;
    logic [REGIONS-1:0] pend_mask_q;
    logic               resp_valid_q;
    logic [DATA_W-1:0]  resp_data_q;

    logic               idle, accept, hit, dirty_victim, reg_hit;
    logic [TAG_W-1:0]   look_tag;

    assign idle      = (state_q == C_IDLE);
    assign inv_en    = idle && (phase_end || pend_q);
    assign inv_mask  = (phase_end ? phase_mask : '0) | pend_mask_q;
    assign req_ready = idle && !inv_en;
    assign accept    = req_valid && req_ready;

    assign look_idx  = idle ? req_addr[IDX_W-1:0]      : cur_addr_q[IDX_W-1:0];
    assign look_tag  = idle ? req_addr[ADDR_W-1:IDX_W] : cur_addr_q[ADDR_W-1:IDX_W];

    assign hit          = (rd_state != LS_INVALID) && (rd_tag == look_tag);
    assign reg_hit      = hit && (rd_state == LS_REGISTERED);
    assign dirty_victim = (rd_state == LS_REGISTERED) && (rd_tag != look_tag);

    assign resp_valid = resp_valid_q;
    assign resp_rdata = resp_data_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE: begin
                if (accept) begin
                    if (!req_we) begin
                        if (!hit) state_d = dirty_victim ? C_EVICT : C_FETCH;
                    end else if (!reg_hit) begin
                        state_d = dirty_victim ? C_EVICT : C_REGISTER;
                    end
                end
            end
            C_EVICT:    if (mem_req_ready) state_d = cur_we_q ? C_REGISTER : C_FETCH;
            C_REGISTER: if (mem_req_ready) state_d = C_IDLE;
            C_FETCH:    if (mem_req_ready) state_d = C_FILL;
            C_FILL:     if (mem_resp_valid) state_d = C_IDLE;
            default:    state_d = C_IDLE;
        endcase
    end

    // Outputs: shared-level request and line write port
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_op    = MOP_READ;
        mem_req_addr  = cur_addr_q;
        mem_req_wdata = '0;
        wr_en         = 1'b0;
        wr_state      = LS_INVALID;
        wr_tag        = look_tag;
        wr_region     = cur_region_q;
        wr_data       = cur_wdata_q;
        unique case (state_q)
            C_IDLE: begin
                if (accept && req_we && reg_hit) begin
                    wr_en     = 1'b1;
                    wr_state  = LS_REGISTERED;
                    wr_region = req_region;
                    wr_data   = req_wdata;
                end
            end
            C_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_op    = MOP_WRITEBACK;
                mem_req_addr  = vict_addr_q;
                mem_req_wdata = vict_data_q;
                if (mem_req_ready) begin
                    wr_en     = 1'b1;
                    wr_state  = LS_INVALID;
                    wr_tag    = rd_tag;
                    wr_region = rd_region;
                    wr_data   = rd_data;
                end
            end
            C_REGISTER: begin
                mem_req_valid = 1'b1;
                mem_req_op    = MOP_REGISTER;
                mem_req_wdata = cur_wdata_q;
                if (mem_req_ready) begin
                    wr_en    = 1'b1;
                    wr_state = LS_REGISTERED;
                end
            end
            C_FETCH: begin
                mem_req_valid = 1'b1;
            end
            C_FILL: begin
                if (mem_resp_valid) begin
                    wr_en    = 1'b1;
                    wr_state = LS_VALID;
                    wr_data  = mem_resp_rdata;
                end
            end
            default: ;
        endcase
    end

    // Request capture, held phase-end, core response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_we_q     <= 1'b0;
            cur_addr_q   <= '0;
            cur_region_q <= '0;
            cur_wdata_q  <= '0;
            vict_addr_q  <= '0;
            vict_data_q  <= '0;
            pend_q       <= 1'b0;
            pend_mask_q  <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            if (inv_en) begin
                pend_q      <= 1'b0;
                pend_mask_q <= '0;
            end else if (phase_end) begin
                pend_q      <= 1'b1;
                pend_mask_q <= pend_mask_q | phase_mask;
            end
            if (accept) begin
                cur_we_q     <= req_we;
                cur_addr_q   <= req_addr;
                cur_region_q <= req_region;
                cur_wdata_q  <= req_wdata;
                vict_addr_q  <= {rd_tag, req_addr[IDX_W-1:0]};
                vict_data_q  <= rd_data;
                if (!req_we && hit) begin
                    resp_valid_q <= 1'b1;
                    resp_data_q  <= rd_data;
                end else if (req_we && reg_hit) begin
                    resp_valid_q <= 1'b1;
                    resp_data_q  <= req_wdata;
                end
            end
            if (state_q == C_REGISTER && mem_req_ready) begin
                resp_valid_q <= 1'b1;
                resp_data_q  <= cur_wdata_q;
            end
            if (state_q == C_FILL && mem_resp_valid) begin
                resp_valid_q <= 1'b1;
                resp_data_q  <= mem_resp_rdata;
            end
        end
    end

endmodule

// File: rtl/l1si_cache.sv
module l1si_cache
    import l1si_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int LINES   = 8,
    parameter int REGIONS = 8,
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int RGN_W  = $clog2(REGIONS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [RGN_W-1:0]   req_region,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               resp_valid,
    output logic [DATA_W-1:0]  resp_rdata,
    input  logic               phase_end,
    input  logic [REGIONS-1:0] phase_mask,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [1:0]         mem_req_op,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [DATA_W-1:0]  mem_req_wdata,
    input  logic               mem_resp_valid,
    input  logic [DATA_W-1:0]  mem_resp_rdata
);

    logic [IDX_W-1:0]   look_idx;
    line_state_e        rd_state, wr_state;
    logic [TAG_W-1:0]   rd_tag, wr_tag;
    logic [RGN_W-1:0]   rd_region, wr_region;
    logic [DATA_W-1:0]  rd_data, wr_data;
    logic               wr_en, inv_en;
    logic [REGIONS-1:0] inv_mask;
    mem_op_e            op;

    assign mem_req_op = op;

    l1si_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .REGIONS(REGIONS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_region(req_region), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .phase_end(phase_end), .phase_mask(phase_mask),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_op(op), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata),
        .look_idx(look_idx),
        .rd_state(rd_state), .rd_tag(rd_tag), .rd_region(rd_region), .rd_data(rd_data),
        .wr_en(wr_en), .wr_state(wr_state), .wr_tag(wr_tag),
        .wr_region(wr_region), .wr_data(wr_data),
        .inv_en(inv_en), .inv_mask(inv_mask)
    );

    l1si_line_array #(
        .LINES(LINES), .TAG_W(TAG_W), .REGIONS(REGIONS), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(look_idx), .rd_state(rd_state), .rd_tag(rd_tag),
        .rd_region(rd_region), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(look_idx), .wr_state(wr_state), .wr_tag(wr_tag),
        .wr_region(wr_region), .wr_data(wr_data),
        .inv_en(inv_en), .inv_mask(inv_mask)
    );

endmodule

// File: rtl/l1si_cache_chk.sv
module l1si_cache_chk #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int REGIONS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_we,
    input logic              resp_valid,
    input logic              phase_end,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [1:0]        mem_req_op,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata
);

    p_load_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_we) |=> (resp_valid || mem_req_valid));

    p_store_answered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_we) |=> (resp_valid || mem_req_valid));

    p_busy_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && mem_req_valid));

    p_stall_on_inval_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_end |-> !req_ready);

    p_hold_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_op) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

endmodule

bind l1si_cache l1si_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REGIONS(REGIONS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .resp_valid(resp_valid), .phase_end(phase_end),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/test_l1si_cache.sv
module test_l1si_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [2:0]  req_region = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, resp_valid;
    logic [31:0] resp_rdata;
    logic        phase_end = 1'b0;
    logic [7:0]  phase_mask = '0;
    logic        mem_req_valid, mem_req_ready;
    logic [1:0]  mem_req_op;
    logic [7:0]  mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_rdata = '0;

    logic        rdy_q = 1'b0;
    logic [31:0] mem [256];
    int          rd_cnt = 0, reg_cnt = 0, wb_cnt = 0;
    logic [7:0]  wb_addr = '0;
    logic [31:0] wb_data = '0;

    int          total = 0, bad = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    bit          done = 0;

    always #4 clk = ~clk;

    assign mem_req_ready = rdy_q;

    l1si_cache i_l1si_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_region(req_region), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .phase_end(phase_end), .phase_mask(phase_mask),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
    );

    function automatic logic [31:0] seed(input int a);
        return 32'h5EED_0000 | a;
    endfunction

    initial for (int i = 0; i < 256; i++) mem[i] = seed(i);

    // Shared-level model: ready every other cycle, read data one cycle later
    always @(posedge clk) begin
        rdy_q <= !rdy_q;
        mem_resp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            case (mem_req_op)
                2'd0: begin
                    mem_resp_valid <= 1'b1;
                    mem_resp_rdata <= mem[mem_req_addr];
                    rd_cnt <= rd_cnt + 1;
                end
                2'd1: reg_cnt <= reg_cnt + 1;
                default: begin
                    mem[mem_req_addr] <= mem_req_wdata;
                    wb_cnt  <= wb_cnt + 1;
                    wb_addr <= mem_req_addr;
                    wb_data <= mem_req_wdata;
                end
            endcase
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    // Monitor: compare each core response with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "unexpected response", int'(resp_rdata), 0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(resp_rdata == e, t, int'(resp_rdata), int'(e));
            end
        end
    end

    task automatic wait_resp();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input bit we, input logic [7:0] a, input logic [2:0] r,
                         input logic [31:0] wd, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_region = r; req_wdata = wd;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic access(input bit we, input logic [7:0] a, input logic [2:0] r,
                          input logic [31:0] wd, input logic [31:0] e, input string t);
        issue(we, a, r, wd, e, t);
        wait_resp();
    endtask

    task automatic phase(input logic [7:0] m);
        @(negedge clk);
        phase_end = 1'b1; phase_mask = m;
        #1;
        check(req_ready == 1'b0, "R8 ready low in invalidate cycle", int'(req_ready), 0);
        @(negedge clk);
        phase_end = 1'b0; phase_mask = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r0, g0, w0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R1 no response after reset", int'(resp_valid), 0);
        check(mem_req_valid == 1'b0, "R1 no shared request after reset", int'(mem_req_valid), 0);

        // R3: load miss fills, R1 lines start Invalid
        r0 = rd_cnt;
        access(0, 8'h01, 3'd1, 0, seed(1), "R3 miss data");
        check(rd_cnt == r0 + 1, "R3 one read on miss", rd_cnt - r0, 1);
        // R2: load hit
        access(0, 8'h01, 3'd1, 0, seed(1), "R2 hit data");
        check(rd_cnt == r0 + 1, "R2 hit sends no read", rd_cnt - r0, 1);

        // R4: store registers, second store does not
        g0 = reg_cnt;
        access(1, 8'h02, 3'd2, 32'h1111, 32'h1111, "R4 store ack");
        check(reg_cnt == g0 + 1, "R4 registration sent", reg_cnt - g0, 1);
        access(1, 8'h02, 3'd2, 32'h3333, 32'h3333, "R4 store ack on registered");
        check(reg_cnt == g0 + 1, "R4 registered hit silent", reg_cnt - g0, 1);
        access(0, 8'h02, 3'd2, 0, 32'h3333, "R2 load of registered word");

        // R6: masked Valid line dropped, Registered kept
        phase(8'h06);
        r0 = rd_cnt;
        access(0, 8'h02, 3'd2, 0, 32'h3333, "R6 registered survives");
        check(rd_cnt == r0, "R6 registered line still hits", rd_cnt - r0, 0);
        access(0, 8'h01, 3'd1, 0, seed(1), "R6 refetch data");
        check(rd_cnt == r0 + 1, "R6 invalidated line misses", rd_cnt - r0, 1);

        // R7: unmasked regions untouched
        access(0, 8'h03, 3'd3, 0, seed(3), "R3 miss data");
        phase(8'h20);
        r0 = rd_cnt;
        access(0, 8'h03, 3'd3, 0, seed(3), "R7 hit after phase");
        access(0, 8'h01, 3'd1, 0, seed(1), "R7 hit after phase");
        check(rd_cnt == r0, "R7 unmasked lines keep state", rd_cnt - r0, 0);

        // R5: eviction of registered word
        w0 = wb_cnt;
        access(1, 8'h0A, 3'd2, 32'h2222, 32'h2222, "R5 store after evict");
        check(wb_cnt == w0 + 1, "R5 write-back sent", wb_cnt - w0, 1);
        check(wb_addr == 8'h02, "R5 write-back address", int'(wb_addr), 2);
        check(wb_data == 32'h3333, "R5 write-back data", int'(wb_data), 32'h3333);
        access(0, 8'h02, 3'd2, 0, 32'h3333, "R5 displaced word reloaded");
        check(wb_addr == 8'h0A && wb_data == 32'h2222, "R5 second write-back",
              int'(wb_data), 32'h2222);
        access(0, 8'h0A, 3'd2, 0, 32'h2222, "R5 reload of written-back word");

        // R8: phase_end and request in the same cycle
        r0 = rd_cnt;
        exp_q.push_back(seed(1));
        tag_q.push_back("R8 load after same-cycle invalidate");
        @(negedge clk);
        phase_end = 1'b1; phase_mask = 8'h02;
        req_valid = 1'b1; req_we = 1'b0; req_addr = 8'h01; req_region = 3'd1;
        #1;
        check(req_ready == 1'b0, "R8 request stalled", int'(req_ready), 0);
        @(negedge clk);
        phase_end = 1'b0; phase_mask = '0;
        #1;
        check(req_ready == 1'b1, "R8 ready returns", int'(req_ready), 1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_resp();
        check(rd_cnt == r0 + 1, "R8 request saw invalidation", rd_cnt - r0, 1);

        // R9: phase_end held while a fill is outstanding
        issue(0, 8'h0C, 3'd4, 0, seed(12), "R9 in-flight load");
        @(negedge clk);
        phase_end = 1'b1; phase_mask = 8'h08;
        @(negedge clk);
        phase_end = 1'b0; phase_mask = '0;
        wait_resp();
        r0 = rd_cnt;
        access(0, 8'h03, 3'd3, 0, seed(3), "R9 data after held invalidate");
        check(rd_cnt == r0 + 1, "R9 held mask applied", rd_cnt - r0, 1);
        access(0, 8'h0C, 3'd4, 0, seed(12), "R9 unmasked fill kept");
        check(rd_cnt == r0 + 1, "R9 fill line unaffected", rd_cnt - r0, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule